// File: doc/BRIEF.md
# Serial Channel Transmitter with Priority Queue

This block is the sending half of one asynchronous serial channel. A host writes characters through a small register port. Normal traffic goes into a main byte queue. Urgent characters, such as flow-control bytes, go into a small priority queue, and that queue is always emptied first. One character at a time moves into a single holding register. From there it is loaded into a shift register and sent least significant bit first. The frame has one start bit, 7 or 8 data bits, an optional odd or even parity bit, and one or two stop bits.

The bit clock comes from a fixed prescaler followed by a programmable 16-bit divisor N. One bit therefore lasts PRESCALE*(N+1) clock cycles. The start of a new character can be held back by three things: a deasserted clear-to-send input when hardware flow control is on, a software-off hold, or a break request. The host drives the modem outputs directly from the output-control register. It can send a break, which holds the line low, and it can route the serial stream to a loopback output for a local receiver.

Register map, written through `wr_addr` and read through `rd_addr`:

| Address | Write | Read |
|---|---|---|
| 0 | push a byte into the main queue | status: bit2 = main queue empty, bit1 = shift register empty |
| 1 | push a byte into the priority queue | main queue count |
| 2 | line format | priority count: bits 5:0 = count, bit7 = priority data pending |
| 3 | output control | 0 |
| 4 | divisor low byte | 0 |
| 5 | divisor high byte | 0 |
| 6 | command | 0 |
| 7 | no effect | 0 |

Top module: `uart_tx_chan`

## Requirements
- R1: After reset the serial output is high and `dtr_o` and `rts_o` are low. The status read (address 0) returns 0x06, and both count reads (addresses 1 and 2) return 0.
- R2: Each character is sent as one low start bit, then the data bits least significant first, then the stop bits, all high. Every bit lasts PRESCALE*(N+1) cycles, where N is the divisor written at addresses 4 (low byte) and 5 (high byte). Format bit0 set selects 8 data bits. Format bit0 clear selects 7 data bits, and bit7 of the written byte is then dropped.
- R3: Format bit2 adds a parity bit after the data. Format bit1 set makes the parity even; clear makes it odd. Format bit3 selects two stop bits instead of one.
- R4: A byte written to address 1 goes into a 32-entry priority queue. Every priority byte is sent before any byte waiting in the main queue. The read at address 2 returns the priority count in bits 5:0, and bit7 is set whenever that count is nonzero.
- R5: The main queue holds 255 bytes. A write to a full queue is dropped. The read at address 1 returns the number of bytes waiting.
- R6: Output-control bit0 (transmit enable) gates only the move of a byte into the holding register. After it is cleared, the byte in the holding register and the byte in the shift register are still sent, and nothing more leaves either queue.
- R7: Status bit2 is set while the main queue is empty. Status bit1 is set while no character is being shifted out. The channel is drained when the status reads 0x06.
- R8: When format bit7 is set and `cts_i` is low, no new character starts. A character already started runs to completion.
- R9: Output-control bit4 (break) holds the line low once the current character has finished. While break is set, no new character starts. Break stays in force until the host clears the bit.
- R10: Output-control bit3 (loopback) holds `txd_o` high and drives the serial stream onto `loop_txd_o`. `loop_txd_o` is high whenever loopback is off.
- R11: `dtr_o` follows output-control bit2 and `rts_o` follows bit1.
- R12: A write to the command register (address 6) acts on three bits. Bit4 empties the main queue, so its count reads 0. Bit5 empties the priority queue. Bit6 releases the software-off hold that a pulse on `xoff_i` sets. While that hold is set, no new character starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register write address |
| wr_data | input | 8 | register write data |
| rd_addr | input | 3 | register read address |
| rd_data | output | 8 | register read data (combinational) |
| cts_i | input | 1 | clear-to-send, high = asserted |
| xoff_i | input | 1 | pulse from the receiver that sets the software-off hold |
| txd_o | output | 1 | serial line output |
| loop_txd_o | output | 1 | serial stream for local loopback |
| dtr_o | output | 1 | data-terminal-ready output |
| rts_o | output | 1 | request-to-send output |

## Verification
The in-RTL properties are checked on every cycle. They cover:
- each new frame starts with a low start bit and has a legal length;
- the main queue never delivers while priority data waits;
- the holding register loads only while transmit is enabled;
- clear-to-send, software-off and break each stop a new character from starting;
- the queue count stays in bounds, and a write to a full queue is dropped.

Other behaviours need the bench's scenarios and its line decoder to show them. These are the exact bit order and bit length for each divisor, parity values, the second stop bit, and the two-byte drain after transmit enable is cleared. They also include 255-byte capacity at the ports, the queue-clear command, and break holding the line low after the character in flight.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DIV_W = 16;

    // register addresses
    localparam logic [2:0] A_MAIN = 3'd0;
    localparam logic [2:0] A_PRIO = 3'd1;
    localparam logic [2:0] A_FMT  = 3'd2;
    localparam logic [2:0] A_CTL  = 3'd3;
    localparam logic [2:0] A_DIVL = 3'd4;
    localparam logic [2:0] A_DIVH = 3'd5;
    localparam logic [2:0] A_CMD  = 3'd6;

    typedef struct packed {
        logic cts_fc;
        logic stop2;
        logic par_en;
        logic even;
        logic eight;
    } fmt_t;

    typedef struct packed {
        logic brk;
        logic loop;
        logic dtr;
        logic rts;
        logic en;
    } ctl_t;

    typedef struct packed {
        logic [11:0] bits;
        logic [3:0]  len;
    } frame_t;

    // Lays out start, data, optional parity and stop bits, LSB first.
    function automatic frame_t build_frame(input logic [7:0] d, input fmt_t f);
        logic [11:0] bits;
        logic [3:0]  pos;
        logic        p;
        bits    = '1;
        bits[0] = 1'b0;
        pos     = 4'd1;
        for (int i = 0; i < 8; i++) begin
            if (i < 7 || f.eight) begin
                bits[pos] = d[i];
                pos       = pos + 4'd1;
            end
        end
        p = f.eight ? ^d : ^d[6:0];
        if (f.par_en) begin
            bits[pos] = f.even ? p : ~p;
            pos       = pos + 4'd1;
        end
        pos = pos + (f.stop2 ? 4'd2 : 4'd1);
        return '{bits: bits, len: pos};
    endfunction

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int DEPTH = 255,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == FULLV);
    assign count = st_q.cnt;
    assign dout  = mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full && !clear;
        do_pop  = pop && !empty && !clear;
        if (clear) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
            if (do_pop)  st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
            if (do_push && !do_pop) st_d.cnt = st_q.cnt + 1'b1;
            else if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= din;
    end

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULLV);
    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clear) |=> $stable(st_q.cnt));
endmodule

// File: rtl/utx_baud.sv
module utx_baud import uart_tx_pkg::*; #(
    parameter int PRESCALE = 10,
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             bit_tick
);
    typedef struct packed {
        logic [PW-1:0]    pre;
        logic [DIV_W-1:0] dcnt;
    } baud_st_t;

    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    baud_st_t st_d, st_q;
    logic pre_tick;

    always_comb begin
        st_d     = st_q;
        pre_tick = (st_q.pre == PRE_LAST);
        bit_tick = pre_tick && (st_q.dcnt >= div);
        st_d.pre = pre_tick ? '0 : st_q.pre + 1'b1;
        if (pre_tick) st_d.dcnt = bit_tick ? '0 : st_q.dcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/utx_serializer.sv
module utx_serializer import uart_tx_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       hold_v,
    input  logic [7:0] hold_byte,
    input  fmt_t       fmt,
    input  logic       cts_i,
    input  logic       xoff_hold,
    input  logic       brk,
    output logic       take,
    output logic       busy,
    output logic       line
);
    typedef struct packed {
        logic [11:0] sr;
        logic [3:0]  left;
    } ser_st_t;

    ser_st_t st_d, st_q;
    frame_t  fr;
    logic    can_go, last;

    always_comb begin
        st_d   = st_q;
        busy   = (st_q.left != '0);
        last   = (st_q.left == 4'd1);
        can_go = !brk && !xoff_hold && (!fmt.cts_fc || cts_i);
        take   = bit_tick && hold_v && can_go && (!busy || last);
        fr     = build_frame(hold_byte, fmt);
        if (take) begin
            st_d.sr   = fr.bits;
            st_d.left = fr.len;
        end else if (bit_tick && busy) begin
            st_d.sr   = {1'b1, st_q.sr[11:1]};
            st_d.left = st_q.left - 4'd1;
        end
        line = busy ? st_q.sr[0] : !brk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (line == 1'b0));
    // R2
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (st_q.left >= 4'd9 && st_q.left <= 4'd12));
    // R9
    no_start_in_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && !busy) |=> !busy);
endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan import uart_tx_pkg::*; #(
    parameter int PRESCALE   = 10,
    parameter int MAIN_DEPTH = 255,
    parameter int PRIO_DEPTH = 32,
    localparam int MCW = $clog2(MAIN_DEPTH + 1),
    localparam int PCW = $clog2(PRIO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       cts_i,
    input  logic       xoff_i,
    output logic       txd_o,
    output logic       loop_txd_o,
    output logic       dtr_o,
    output logic       rts_o
);
    typedef struct packed {
        fmt_t             fmt;
        ctl_t             ctl;
        logic [DIV_W-1:0] div;
        logic             xoff_hold;
        logic [7:0]       hold;
        logic             hold_v;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic main_push, main_pop, main_clr, main_empty, main_full;
    logic prio_push, prio_pop, prio_clr, prio_empty, prio_full;
    logic [7:0] main_dout, prio_dout;
    logic [MCW-1:0] main_cnt;
    logic [PCW-1:0] prio_cnt;
    logic bit_tick, ser_take, ser_busy, ser_line, ovr;

    utx_fifo #(.DEPTH(MAIN_DEPTH), .W(8)) main_q_i (
        .clk(clk), .rst_n(rst_n), .clear(main_clr), .push(main_push), .din(wr_data),
        .pop(main_pop), .dout(main_dout), .count(main_cnt), .empty(main_empty), .full(main_full));

    utx_fifo #(.DEPTH(PRIO_DEPTH), .W(8)) prio_q_i (
        .clk(clk), .rst_n(rst_n), .clear(prio_clr), .push(prio_push), .din(wr_data),
        .pop(prio_pop), .dout(prio_dout), .count(prio_cnt), .empty(prio_empty), .full(prio_full));

    utx_baud #(.PRESCALE(PRESCALE)) baud_i (
        .clk(clk), .rst_n(rst_n), .div(st_q.div), .bit_tick(bit_tick));

    utx_serializer ser_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .hold_v(st_q.hold_v),
        .hold_byte(st_q.hold), .fmt(st_q.fmt), .cts_i(cts_i), .xoff_hold(st_q.xoff_hold),
        .brk(st_q.ctl.brk), .take(ser_take), .busy(ser_busy), .line(ser_line));

    always_comb begin
        st_d      = st_q;
        main_push = 1'b0;
        prio_push = 1'b0;
        main_clr  = 1'b0;
        prio_clr  = 1'b0;
        main_pop  = 1'b0;
        prio_pop  = 1'b0;
        ovr       = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                A_MAIN: main_push = 1'b1;
                A_PRIO: prio_push = 1'b1;
                A_FMT:  st_d.fmt = '{cts_fc: wr_data[7], stop2: wr_data[3],
                                     par_en: wr_data[2], even: wr_data[1], eight: wr_data[0]};
                A_CTL:  st_d.ctl = '{brk: wr_data[4], loop: wr_data[3],
                                     dtr: wr_data[2], rts: wr_data[1], en: wr_data[0]};
                A_DIVL: st_d.div[7:0]  = wr_data;
                A_DIVH: st_d.div[15:8] = wr_data;
                A_CMD: begin
                    main_clr = wr_data[4];
                    prio_clr = wr_data[5];
                    ovr      = wr_data[6];
                end
                default: ;
            endcase
        end
        if (xoff_i) st_d.xoff_hold = 1'b1;
        if (ovr)    st_d.xoff_hold = 1'b0;
        // holding register: priority source first, both gated by transmit enable
        if (ser_take) begin
            st_d.hold_v = 1'b0;
        end else if (!st_q.hold_v && st_q.ctl.en) begin
            if (!prio_empty) begin
                prio_pop    = 1'b1;
                st_d.hold   = prio_dout;
                st_d.hold_v = 1'b1;
            end else if (!main_empty) begin
                main_pop    = 1'b1;
                st_d.hold   = main_dout;
                st_d.hold_v = 1'b1;
            end
        end
        case (rd_addr)
            3'd0:    rd_data = {5'd0, main_empty, !ser_busy, 1'b0};
            3'd1:    rd_data = 8'(main_cnt);
            3'd2:    rd_data = {!prio_empty, 1'b0, 6'(prio_cnt)};
            default: rd_data = 8'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign txd_o      = st_q.ctl.loop ? 1'b1 : ser_line;
    assign loop_txd_o = st_q.ctl.loop ? ser_line : 1'b1;
    assign dtr_o      = st_q.ctl.dtr;
    assign rts_o      = st_q.ctl.rts;

    // R4
    prio_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_pop |-> prio_empty);
    // R6
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hold_v) |-> $past(st_q.ctl.en));
    // R8
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fmt.cts_fc && !cts_i && !ser_busy) |=> !ser_busy);
    // R12
    xoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.xoff_hold && !ser_busy) |=> !ser_busy);
    // R5
    full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (main_full || prio_full) |-> !(main_empty && prio_empty));
endmodule

// File: tb/uart_tx_chan_tb_top.sv
module uart_tx_chan_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic cts_i = 1'b1;
    logic xoff_i = 1'b0;
    logic txd_o, loop_txd_o, dtr_o, rts_o;

    uart_tx_chan dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cts_i(cts_i), .xoff_i(xoff_i),
        .txd_o(txd_o), .loop_txd_o(loop_txd_o), .dtr_o(dtr_o), .rts_o(rts_o));

    always #2 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int bit_per = 10;
    bit fmt8 = 1'b1, fpar = 1'b0, feven = 1'b0, fstop2 = 1'b0;
    bit mon_en = 1'b1;
    bit live = 1'b0;
    bit exp_loop = 1'b0, exp_dtr = 1'b0, exp_rts = 1'b0;
    logic [7:0] rx_q[$];
    logic [7:0] exp_q[$];
    wire line = txd_o & loop_txd_o;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (a == 3'd3) begin exp_loop = d[3]; exp_dtr = d[2]; exp_rts = d[1]; end
        if (a == 3'd2) begin fmt8 = d[0]; feven = d[1]; fpar = d[2]; fstop2 = d[3]; end
    endtask

    task automatic rdv(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        logic [7:0] v;
        rdv(a, v);
        chk(v == e, tag, v, e);
    endtask

    task automatic send(input logic [7:0] d, input logic [7:0] e);
        wr(3'd0, d);
        exp_q.push_back(e);
    endtask

    task automatic wait_drained();
        logic [7:0] v;
        repeat (2 * bit_per + 4) @(negedge clk);
        for (int i = 0; i < 40000; i++) begin
            rdv(3'd0, v);
            if (v == 8'h06) break;
        end
        repeat (bit_per) @(negedge clk);
    endtask

    task automatic check_rx(input string tag);
        chk(rx_q.size() == exp_q.size(), {tag, " byte count"}, rx_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
            chk(rx_q[i] == exp_q[i], {tag, " byte value"}, rx_q[i], exp_q[i]);
        rx_q.delete();
        exp_q.delete();
    endtask

    // line decoder: behavioural receiver using the format the bench programmed
    initial begin
        logic [7:0] d;
        logic p;
        int nb;
        forever begin
            @(negedge clk);
            if (mon_en && live && line == 1'b0) begin
                d = '0;
                nb = fmt8 ? 8 : 7;
                repeat (bit_per / 2) @(negedge clk);
                chk(line == 1'b0, "R2 start bit", line, 0);
                for (int i = 0; i < nb; i++) begin
                    repeat (bit_per) @(negedge clk);
                    d[i] = line;
                end
                if (fpar) begin
                    repeat (bit_per) @(negedge clk);
                    p = fmt8 ? ^d : ^d[6:0];
                    if (!feven) p = ~p;
                    chk(line == p, "R3 parity bit", line, p);
                end
                repeat (bit_per) @(negedge clk);
                chk(line == 1'b1, "R2 stop bit", line, 1);
                if (fstop2) begin
                    repeat (bit_per) @(negedge clk);
                    chk(line == 1'b1, "R3 second stop bit", line, 1);
                end
                rx_q.push_back(d);
            end
        end
    end

    // per-cycle comparison of the directly controlled outputs
    always @(negedge clk) begin
        if (live) begin
            chk(dtr_o == exp_dtr, "R11 dtr", dtr_o, exp_dtr);
            chk(rts_o == exp_rts, "R11 rts", rts_o, exp_rts);
            if (exp_loop) chk(txd_o == 1'b1, "R10 txd held high in loopback", txd_o, 1);
            else          chk(loop_txd_o == 1'b1, "R10 loopback output idle", loop_txd_o, 1);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        // R1 reset state
        rd_chk(3'd0, 8'h06, "R1 status after reset");
        rd_chk(3'd1, 8'h00, "R1 main count after reset");
        rd_chk(3'd2, 8'h00, "R1 priority count after reset");
        chk(txd_o == 1'b1, "R1 line idle high", txd_o, 1);
        chk(dtr_o == 1'b0 && rts_o == 1'b0, "R1 modem outputs low", {dtr_o, rts_o}, 0);

        // R2 8N1, divisor 0
        wr(3'd2, 8'h01);
        wr(3'd3, 8'h01);
        send(8'hA5, 8'hA5); send(8'h3C, 8'h3C); send(8'hFF, 8'hFF); send(8'h00, 8'h00);
        repeat (15) @(negedge clk);
        rdv(3'd0, v);
        chk(v[1] == 1'b0, "R7 shift register busy", v[1], 0);
        wait_drained();
        check_rx("R2 8N1");

        // R3 7 data bits, even parity; top bit dropped
        wr(3'd2, 8'h06);
        send(8'hC1, 8'h41); send(8'h7F, 8'h7F); send(8'h03, 8'h03);
        wait_drained();
        check_rx("R3 7E1");

        // R3 8 data bits, odd parity, two stops
        wr(3'd2, 8'h0D);
        send(8'h96, 8'h96); send(8'h01, 8'h01); send(8'hE7, 8'hE7);
        wait_drained();
        check_rx("R3 8O2");

        // R2 divisor 3 -> 40 cycles per bit
        wr(3'd2, 8'h01);
        wr(3'd4, 8'h03);
        wr(3'd5, 8'h00);
        bit_per = 40;
        send(8'h55, 8'h55); send(8'hC3, 8'hC3);
        wait_drained();
        check_rx("R2 divisor 3");
        wr(3'd4, 8'h00);
        bit_per = 10;

        // R4 priority ahead of main queue
        wr(3'd3, 8'h00);
        send(8'h11, 8'h77); send(8'h22, 8'h88);
        wr(3'd1, 8'h77); wr(3'd1, 8'h88);
        exp_q.delete();
        exp_q.push_back(8'h77); exp_q.push_back(8'h88);
        exp_q.push_back(8'h11); exp_q.push_back(8'h22);
        rd_chk(3'd2, 8'h82, "R4 priority count with pending bit");
        rd_chk(3'd1, 8'h02, "R5 main count");
        wr(3'd3, 8'h01);
        wait_drained();
        rd_chk(3'd2, 8'h00, "R4 pending clear after send");
        check_rx("R4 priority order");

        // R6 disabling transmit drains exactly two bytes
        wr(3'd0, 8'h31); wr(3'd0, 8'h32); wr(3'd0, 8'h33); wr(3'd0, 8'h34);
        for (int i = 0; i < 200; i++) begin
            rdv(3'd0, v);
            if (v[1] == 1'b0) break;
        end
        repeat (3) @(negedge clk);
        wr(3'd3, 8'h00);
        repeat (300) @(negedge clk);
        exp_q.push_back(8'h31); exp_q.push_back(8'h32);
        check_rx("R6 drain after disable");
        rd_chk(3'd1, 8'h02, "R6 bytes left in queue");
        rd_chk(3'd0, 8'h02, "R7 queue not empty, shifter empty");
        // R12 clear main queue
        wr(3'd6, 8'h10);
        rd_chk(3'd1, 8'h00, "R12 count cleared");
        rd_chk(3'd0, 8'h06, "R12 status drained after clear");
        wr(3'd3, 8'h01);
        repeat (300) @(negedge clk);
        check_rx("R12 cleared bytes not sent");
        // R12 clear priority queue
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h44);
        wr(3'd6, 8'h20);
        rd_chk(3'd2, 8'h00, "R12 priority cleared");
        wr(3'd3, 8'h01);

        // R5 capacity 255, the 256th write dropped
        wr(3'd3, 8'h00);
        for (int i = 0; i < 256; i++) begin
            wr(3'd0, 8'(i));
            if (i < 255) exp_q.push_back(8'(i));
        end
        rd_chk(3'd1, 8'hFF, "R5 full count");
        rd_chk(3'd0, 8'h02, "R7 queue full status");
        wr(3'd3, 8'h01);
        wait_drained();
        check_rx("R5 full queue contents");

        // R8 clear-to-send flow control
        wr(3'd2, 8'h81);
        cts_i = 1'b0;
        send(8'h3C, 8'h3C);
        repeat (300) @(negedge clk);
        chk(rx_q.size() == 0, "R8 no start while cts low", rx_q.size(), 0);
        cts_i = 1'b1;
        wait_drained();
        check_rx("R8 sent after cts");
        wr(3'd2, 8'h01);

        // R12 software-off hold and override
        @(negedge clk); xoff_i = 1'b1;
        @(negedge clk); xoff_i = 1'b0;
        send(8'h5E, 8'h5E);
        repeat (300) @(negedge clk);
        chk(rx_q.size() == 0, "R12 no start during hold", rx_q.size(), 0);
        wr(3'd6, 8'h40);
        wait_drained();
        check_rx("R12 sent after override");

        // R9 break after the current character
        send(8'hF0, 8'hF0);
        for (int i = 0; i < 200; i++) begin
            rdv(3'd0, v);
            if (v[1] == 1'b0) break;
        end
        mon_en = 1'b0;
        wr(3'd3, 8'h11);
        wait_drained();
        chk(txd_o == 1'b0, "R9 line low in break", txd_o, 0);
        wr(3'd0, 8'h0F);
        repeat (300) @(negedge clk);
        chk(txd_o == 1'b0, "R9 line still low", txd_o, 0);
        rd_chk(3'd0, 8'h06, "R9 no character during break");
        wr(3'd3, 8'h01);
        mon_en = 1'b1;
        exp_q.push_back(8'h0F);
        wait_drained();
        check_rx("R9 frame before break and after release");

        // R10 loopback
        wr(3'd3, 8'h09);
        send(8'h5A, 8'h5A);
        repeat (30) @(negedge clk);
        chk(txd_o == 1'b1, "R10 txd high during loopback", txd_o, 1);
        wait_drained();
        check_rx("R10 loopback stream");
        wr(3'd3, 8'h01);

        // R11 modem outputs
        wr(3'd3, 8'h07);
        @(negedge clk);
        chk(dtr_o == 1'b1 && rts_o == 1'b1, "R11 both asserted", {dtr_o, rts_o}, 3);
        wr(3'd3, 8'h03);
        @(negedge clk);
        chk(dtr_o == 1'b0 && rts_o == 1'b1, "R11 dtr dropped", {dtr_o, rts_o}, 1);
        wr(3'd3, 8'h01);

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule